// File: doc/BRIEF.md
# NAND Flash Command/Address Strobe Interface

This block sits between a simple memory-mapped bus and one NAND flash device with an 8- or 16-bit data path. Each bus read or write becomes a single device cycle. Two fixed high address bits pick the cycle's type. One bit selects a command cycle, which raises the command-latch pin. The other selects an address cycle, which raises the address-latch pin. With neither bit set, the access is a plain data transfer.

Every access passes through the same programmable phases. Setup comes first. The write or read strobe then stays low for a programmed width. A hold phase follows, then a one-cycle bus ready, then a high-impedance turnaround gap. The gap must pass before another access can start.

A small configuration port loads two words. The control word sets bank enable, which drives chip-enable. It also selects the device width and turns on waiting for the device's ready/busy line. The timing word packs the four phase lengths into one byte each. The bus master holds its request until it sees the ready pulse, and it reads returned data in that same cycle.

Top module: `nand_strobe_if`

## Requirements
- R1: After reset, chip-enable is high (inactive), command-latch and address-latch are low, both strobes are high, the data bus is not driven and bus ready is low. The control word resets to all-clear: bank disabled, 8-bit width and no ready waiting. The timing word resets to setup 0, strobe 6, hold 4, turnaround 1.
- R2: An access whose address bit 16 is set raises command-latch. If bit 16 is clear and bit 17 is set, address-latch is raised instead. If both are set, only command-latch is raised. The raised pin stays high from the first setup cycle to the last hold cycle, and is low at all other times.
- R3: On a write, the write strobe is low for exactly strobe+1 cycles. These cycles start after the setup cycles. The read strobe stays high throughout.
- R4: On a read, the read strobe is low for exactly strobe+1 cycles after setup. The value on the device data input in the last strobe-low cycle is returned on the bus read data during the ready cycle.
- R5: On a write, the data bus output enable is high from the first setup cycle through the last hold cycle and low otherwise. A read never enables it.
- R6: Bus ready is a one-cycle pulse. It falls setup+strobe+1+hold cycles after the cycle in which the access is accepted.
- R7: After the ready pulse, no new access is accepted during the turnaround cycles or the idle cycle after them, even if a request is held high. A held request is accepted at the end of that idle cycle.
- R8: Chip-enable (active low) is low exactly when control bit 2 (bank enable) is set.
- R9: Control bit 4 set selects 16-bit width. When it is clear, the upper byte of the device write data and of the returned read data is zero.
- R10: When control bit 1 (wait on ready) is set and the ready/busy input is low, a pending request is not accepted. It is accepted at the first clock edge with ready/busy high. When bit 1 is clear, ready/busy has no effect.
- R11: A configuration write with select 0 loads the control word. With select 1 it loads the timing word, laid out as setup [7:0], strobe [15:8], hold [23:16], turnaround [31:24]. The new values govern the next access.
- R12: A setup length of 0 sends the access straight into the strobe phase. A hold length of 0 puts the ready pulse in the cycle right after the last strobe cycle. A turnaround of 0 leaves a single idle cycle before the next accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | AW | Access address; bits CLE_BIT/ALE_BIT select cycle type |
| bus_wr_i | input | 1 | Write request, held until ready |
| bus_rd_i | input | 1 | Read request, held until ready |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid with ready |
| bus_ready_o | output | 1 | One-cycle access completion |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = control word, 1 = timing word |
| cfg_wdata_i | input | 32 | Configuration write value |
| nand_ce_no | output | 1 | Device chip-enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | DW | Device data out |
| nand_dq_oe_o | output | 1 | Device data output enable |
| nand_dq_i | input | DW | Device data in |
| nand_rb_i | input | 1 | Device ready (1) / busy (0) |

## Verification
Take the clock edge that accepts an access as cycle 0. Every device pin then follows a fixed schedule. Setup fills the first setup cycles. The strobe fills the next strobe+1 cycles, and hold fills the following hold cycles. Ready lands in cycle setup+strobe+1+hold, and turnaround plus one idle cycle come after it. Each registered output changes one edge after the state that causes it. The bench model therefore walks this schedule at every falling edge after the accepting edge. It compares every pin and the ready pulse cycle by cycle, and checks returned data only in the ready cycle. For a held-off request, the model shows idle pins until the edge where ready/busy is seen high. For a chained request, it likewise shows idle pins until the edge that ends the idle cycle.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam int CFG_W         = 32;
  localparam int TFIELD_W      = 8;
  localparam int CTRL_WAIT_BIT = 1;
  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_WIDE_BIT = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE, PH_HIZ
  } phase_e;

  typedef enum logic [1:0] {
    CYC_DATA, CYC_CMD, CYC_ADDR
  } cyc_e;

  // packed MSB first: turnaround [31:24] .. setup [7:0]
  typedef struct packed {
    logic [TFIELD_W-1:0] hiz;
    logic [TFIELD_W-1:0] hold;
    logic [TFIELD_W-1:0] strobe;
    logic [TFIELD_W-1:0] setup;
  } timing_t;

  typedef struct packed {
    logic wait_en;
    logic bank_en;
    logic wide;
  } ctrl_t;

  localparam timing_t TIMING_RST = '{hiz: 8'd1, hold: 8'd4, strobe: 8'd6, setup: 8'd0};

endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
  import nand_strobe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output ctrl_t            ctrl_o,
  output timing_t          timing_o
);

  ctrl_t   ctrl_q;
  timing_t timing_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      timing_q <= TIMING_RST;
    end else if (cfg_we_i) begin
      if (cfg_sel_i) begin
        timing_q <= timing_t'(cfg_wdata_i);
      end else begin
        ctrl_q.wait_en <= cfg_wdata_i[CTRL_WAIT_BIT];
        ctrl_q.bank_en <= cfg_wdata_i[CTRL_EN_BIT];
        ctrl_q.wide    <= cfg_wdata_i[CTRL_WIDE_BIT];
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign timing_o = timing_q;

endmodule

// File: rtl/nand_cycle_decode.sv
module nand_cycle_decode
  import nand_strobe_pkg::*;
#(
  parameter int AW      = 18,
  parameter int CLE_BIT = 16,
  parameter int ALE_BIT = 17
) (
  input  logic [AW-1:0] addr_i,
  output cyc_e          cyc_o
);

  logic unused_addr;
  assign unused_addr = ^addr_i;

  // command select wins over address select
  always_comb begin
    if (addr_i[CLE_BIT])      cyc_o = CYC_CMD;
    else if (addr_i[ALE_BIT]) cyc_o = CYC_ADDR;
    else                      cyc_o = CYC_DATA;
  end

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_strobe_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    rb_ok_i,
  input  timing_t timing_i,
  output phase_e  phase_o,
  output logic    accept_o,
  output logic    strobe_end_o
);

  phase_e              phase_q, phase_d;
  logic [TFIELD_W-1:0] cnt_q, cnt_d;
  logic                cnt_zero;

  assign cnt_zero     = (cnt_q == '0);
  assign accept_o     = (phase_q == PH_IDLE) && req_i && rb_ok_i;
  assign strobe_end_o = (phase_q == PH_STROBE) && cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (accept_o) begin
        if (timing_i.setup != '0) begin
          phase_d = PH_SETUP;
          cnt_d   = timing_i.setup - 1'b1;
        end else begin
          phase_d = PH_STROBE;
          cnt_d   = timing_i.strobe;
        end
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d = PH_STROBE;
        cnt_d   = timing_i.strobe;
      end else cnt_d = cnt_q - 1'b1;
      PH_STROBE: if (cnt_zero) begin
        if (timing_i.hold != '0) begin
          phase_d = PH_HOLD;
          cnt_d   = timing_i.hold - 1'b1;
        end else phase_d = PH_DONE;
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_zero) phase_d = PH_DONE;
               else cnt_d = cnt_q - 1'b1;
      PH_DONE: if (timing_i.hiz != '0) begin
        phase_d = PH_HIZ;
        cnt_d   = timing_i.hiz - 1'b1;
      end else phase_d = PH_IDLE;
      PH_HIZ: if (cnt_zero) phase_d = PH_IDLE;
              else cnt_d = cnt_q - 1'b1;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;

  // busy device holds off a pending access
  assert_hold_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !rb_ok_i) |=> (phase_q == PH_IDLE));

  // turnaround is never cut short by a request
  assert_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HIZ && !cnt_zero) |=> (phase_q == PH_HIZ));

endmodule

// File: rtl/nand_strobe_if.sv
module nand_strobe_if
  import nand_strobe_pkg::*;
#(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int CLE_BIT = 16,
  parameter int ALE_BIT = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             bus_ready_o,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [DW-1:0]    nand_dq_o,
  output logic             nand_dq_oe_o,
  input  logic [DW-1:0]    nand_dq_i,
  input  logic             nand_rb_i
);

  localparam int HW = DW / 2;

  ctrl_t   ctrl;
  timing_t timing;
  cyc_e    cyc_dec, cyc_q;
  phase_e  phase;
  logic    accept, strobe_end, busy, rb_ok;
  logic    wr_q;
  logic [DW-1:0] wdata_q, rdata_q, wdata_fit, rdata_fit;

  nand_cfg_regs i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .ctrl_o      (ctrl),
    .timing_o    (timing)
  );

  nand_cycle_decode #(.AW(AW), .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT)) i_dec (
    .addr_i (bus_addr_i),
    .cyc_o  (cyc_dec)
  );

  assign rb_ok = !(ctrl.wait_en && !nand_rb_i);

  nand_phase_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (bus_wr_i || bus_rd_i),
    .rb_ok_i      (rb_ok),
    .timing_i     (timing),
    .phase_o      (phase),
    .accept_o     (accept),
    .strobe_end_o (strobe_end)
  );

  assign wdata_fit = ctrl.wide ? bus_wdata_i : {{(DW-HW){1'b0}}, bus_wdata_i[HW-1:0]};
  assign rdata_fit = ctrl.wide ? nand_dq_i   : {{(DW-HW){1'b0}}, nand_dq_i[HW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= CYC_DATA;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        cyc_q   <= cyc_dec;
        wr_q    <= bus_wr_i;
        wdata_q <= wdata_fit;
      end
      if (strobe_end && !wr_q) rdata_q <= rdata_fit;
    end
  end

  assign busy         = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign nand_ce_no   = !ctrl.bank_en;
  assign nand_cle_o   = busy && (cyc_q == CYC_CMD);
  assign nand_ale_o   = busy && (cyc_q == CYC_ADDR);
  assign nand_we_no   = !((phase == PH_STROBE) && wr_q);
  assign nand_re_no   = !((phase == PH_STROBE) && !wr_q);
  assign nand_dq_oe_o = busy && wr_q;
  assign nand_dq_o    = wdata_q;
  assign bus_ready_o  = (phase == PH_DONE);
  assign bus_rdata_o  = rdata_q;

  assert_strobes_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  assert_latch_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  assert_latch_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(nand_cle_o) && $stable(nand_ale_o)));

  assert_drive_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_dq_oe_o |-> nand_re_no);

  assert_ready_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o |=> !bus_ready_o);

  assert_ready_after_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ready_o) |-> (nand_we_no && nand_re_no && !nand_dq_oe_o));

endmodule

// File: tb/test_nand_strobe_if.sv
module test_nand_strobe_if;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ready;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wd = '0;
  logic        ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [15:0] dq_o;
  logic [15:0] dq_in = '0;
  logic        rb = 1'b1;

  always #2 clk = ~clk;

  nand_strobe_if i_nand_strobe_if (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_ready_o(bus_ready),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wd),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o),
    .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_in), .nand_rb_i(rb)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  // model of the configuration
  int tset = 0, tw = 6, th = 4, tz = 1;
  bit bank = 0, wide = 0;

  // chained follow-on access
  bit          nxt_wr;
  logic [17:0] nxt_addr;
  logic [15:0] nxt_wd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual %h expected %h at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic cfg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wd = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) begin
      tset = d[7:0]; tw = d[15:8]; th = d[23:16]; tz = d[31:24];
    end else begin
      bank = d[2]; wide = d[4];
    end
  endtask

  task automatic start(input bit wr, input logic [17:0] addr,
                       input logic [15:0] wd, input logic [15:0] rdp);
    @(negedge clk);
    bus_addr = addr; bus_wr = wr; bus_rd = !wr; bus_wdata = wd; dq_in = rdp;
  endtask

  // walk the expected schedule; caller has just passed the accepting edge
  task automatic phases(input bit wr, input logic [17:0] addr, input logic [15:0] wd,
                        input logic [15:0] rdp, input bit chain);
    int total, done;
    bit cle_e, ale_e, act, strb;
    done  = tset + tw + 1 + th;
    total = done + 1 + tz + 1;
    cle_e = addr[16];
    ale_e = !addr[16] && addr[17];
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      act  = (i < done);
      strb = (i >= tset) && (i < tset + tw + 1);
      chk(i > done ? "R7 cle" : "R2 cle", cle, act && cle_e);
      chk(i > done ? "R7 ale" : "R2 ale", ale, act && ale_e);
      chk(i > done ? "R7 we_n" : "R3 we_n", we_n, !(strb && wr));
      chk(i > done ? "R7 re_n" : "R4 re_n", re_n, !(strb && !wr));
      chk("R5 dq_oe", dq_oe, act && wr);
      if (act && wr) chk("R9 dq_o", dq_o, wide ? wd : {8'h00, wd[7:0]});
      chk(i > done ? "R7 ready" : "R6 ready", bus_ready, i == done);
      chk("R8 ce_n", ce_n, !bank);
      if (i == done && !wr) chk("R4 rdata", bus_rdata, wide ? rdp : {8'h00, rdp[7:0]});
      if (i == done) begin
        if (chain) begin
          bus_addr = nxt_addr; bus_wr = nxt_wr; bus_rd = !nxt_wr; bus_wdata = nxt_wd;
        end else begin
          bus_wr = 1'b0; bus_rd = 1'b0;
        end
      end
    end
  endtask

  task automatic access(input bit wr, input logic [17:0] addr,
                        input logic [15:0] wd, input logic [15:0] rdp);
    start(wr, addr, wd, rdp);
    @(posedge clk);
    phases(wr, addr, wd, rdp, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1 ce_n", ce_n, 1'b1);
    chk("R1 cle", cle, 1'b0);
    chk("R1 ale", ale, 1'b0);
    chk("R1 we_n", we_n, 1'b1);
    chk("R1 re_n", re_n, 1'b1);
    chk("R1 dq_oe", dq_oe, 1'b0);
    chk("R1 ready", bus_ready, 1'b0);
    // default timing, bank off, 8-bit
    access(1'b1, 18'h00000, 16'hA5C3, 16'h0000);

    tag = "R8";
    cfg(1'b0, 32'h0000_0014);
    access(1'b1, 18'h10000, 16'h0070, 16'h0000);

    tag = "R2";
    access(1'b1, 18'h20000, 16'h1234, 16'h0000);
    access(1'b1, 18'h30000, 16'h00FF, 16'h0000);
    access(1'b0, 18'h00ABC, 16'h0000, 16'hBEEF);

    tag = "R9";
    cfg(1'b0, 32'h0000_0004);
    access(1'b0, 18'h00000, 16'h0000, 16'hBEEF);
    access(1'b1, 18'h00000, 16'h9A5E, 16'h0000);

    tag = "R11";
    cfg(1'b1, 32'h0201_0302);
    access(1'b1, 18'h20000, 16'h0042, 16'h0000);
    access(1'b0, 18'h00000, 16'h0000, 16'h00C6);

    tag = "R12";
    cfg(1'b1, 32'h0000_0000);
    access(1'b0, 18'h00000, 16'h0000, 16'h005A);
    access(1'b1, 18'h10000, 16'h0090, 16'h0000);

    tag = "R7";
    cfg(1'b1, 32'h0300_0101);
    nxt_wr = 1'b0; nxt_addr = 18'h00000; nxt_wd = 16'h0000;
    start(1'b1, 18'h20000, 16'h0033, 16'h0071);
    @(posedge clk);
    phases(1'b1, 18'h20000, 16'h0033, 16'h0071, 1'b1);
    @(posedge clk);
    phases(1'b0, 18'h00000, 16'h0000, 16'h0071, 1'b0);

    tag = "R10";
    cfg(1'b0, 32'h0000_0006);
    rb = 1'b0;
    start(1'b1, 18'h10000, 16'h0060, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 we_n held", we_n, 1'b1);
      chk("R10 cle held", cle, 1'b0);
      chk("R10 ready held", bus_ready, 1'b0);
    end
    rb = 1'b1;
    @(posedge clk);
    phases(1'b1, 18'h10000, 16'h0060, 16'h0000, 1'b0);
    // wait disabled: busy line has no effect
    cfg(1'b0, 32'h0000_0004);
    rb = 1'b0;
    access(1'b0, 18'h00000, 16'h0000, 16'h00D2);
    rb = 1'b1;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule